// File: doc/BRIEF.md
# Quantized Table-Lookup Arithmetic Unit

This unit performs two-operand arithmetic on quantized values without any arithmetic datapath. Each operand is a small codebook index. The unit joins a table number and the two operand indices into one memory address. The word stored at that address is the codebook index of the result. Each table therefore holds exactly one two-operand function. Software fills the tables word by word through a load port before it issues any lookup.

A lookup can name its table in two ways. The first is explicit: the command carries the table number. The second uses a persistent active-table register. A set-table command writes this register, and every later implicit lookup reads from that table until another set-table command or a reset. Each request carries a destination tag. The tag returns with the result, which is valid exactly one cycle after the request is accepted. The tables have different operand widths. For a narrow table, the operand bits above its width are forced to zero when the address is formed.

Top module: `qlut_unit`

## Requirements
- R1: After reset, `res_valid` is 0, `req_ready` is 1, and the active table is table 0, so an implicit lookup reads table 0.
- R2: An accepted lookup with `req_op` = 1 (explicit) returns the entry of table `req_tbl` at operands (`req_a`, `req_b`) on `res_data`. The result appears on the clock edge that accepts the request, and `res_dst` equals `req_dst`.
- R3: `req_op` = 2 (set-table) loads `req_tbl` into the active-table register. Every later lookup with `req_op` = 0 (implicit) reads that table, and the setting persists across any number of lookups.
- R4: A set-table command produces no result. An explicit lookup leaves the active table unchanged.
- R5: The table word address is {table, a, b}: table in bits [9:8], a in bits [7:4] and b in bits [3:0]. This single address format serves both the load port and lookups.
- R6: The operand widths are 4, 4, 3 and 2 bits for tables 0, 1, 2 and 3. For a given table, operand bits at or above its width are ignored and read as zero.
- R7: `req_ready` is 0 in the cycle after a load (`ld_en` = 1) and 1 otherwise. A request presented while `req_ready` is 0 is not accepted and yields no result.
- R8: A lookup accepted in the same cycle as a load to the same address returns the old contents. The next accepted lookup of that address returns the new contents.
- R9: `req_op` = 3 is reserved. It is accepted but gives no result and does not change the active table.
- R10: `res_valid` is high for exactly one cycle per accepted lookup and is low otherwise. Lookups presented back to back give one result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Table word write strobe |
| ld_addr | input | 10 | Word address {table, a, b} |
| ld_data | input | 9 | Result index to store |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 2 | 0 implicit lookup, 1 explicit lookup, 2 set table, 3 reserved |
| req_tbl | input | 2 | Table number for explicit lookup or set-table |
| req_a | input | 4 | First operand index |
| req_b | input | 4 | Second operand index |
| req_dst | input | 4 | Destination tag echoed with the result |
| res_valid | output | 1 | Result valid |
| res_data | output | 9 | Result codebook index |
| res_dst | output | 4 | Destination tag of the result |

## Verification
The hardest case to reach is the read/write collision. A lookup must be accepted in the same cycle as a load to the same word, and then retried after the one-cycle ready drop. The bench drives `ld_en` and `req_valid` together at that address. It checks that the old value returns, holds the request through the stalled cycle and expects no result there, and then reads the new value. The operand masks on the narrow tables are reached by looking up indices that have high bits set in entries that were loaded with distinct values.

// File: rtl/qlut_pkg.sv
package qlut_pkg;

    typedef enum logic [1:0] {
        OP_LOOKUP_ACT = 2'd0,
        OP_LOOKUP_TBL = 2'd1,
        OP_SET_ACT    = 2'd2,
        OP_RSVD       = 2'd3
    } qlut_op_e;

    localparam int DEF_NUM_TABLES = 4;
    localparam int DEF_IDX_W      = 4;
    localparam int DEF_OUT_W      = 9;
    localparam int DEF_DST_W      = 4;
    localparam int IW_FIELD_W     = 4;

endpackage

// File: rtl/qlut_addr.sv
module qlut_addr #(
    parameter int NUM_TABLES = 4,
    parameter int IDX_W      = 4,
    parameter logic [NUM_TABLES*4-1:0] TBL_IW = {4'd2, 4'd3, 4'd4, 4'd4},
    localparam int TID_W  = $clog2(NUM_TABLES),
    localparam int ADDR_W = TID_W + 2 * IDX_W
) (
    input  logic [TID_W-1:0]  tbl,
    input  logic [IDX_W-1:0]  idx_a,
    input  logic [IDX_W-1:0]  idx_b,
    output logic [ADDR_W-1:0] addr
);
    logic [IDX_W-1:0] mask_arr [NUM_TABLES];

    // one operand mask per table, derived from its width field
    for (genvar t = 0; t < NUM_TABLES; t++) begin : g_mask
        localparam int W = int'(TBL_IW[t*4 +: 4]);
        if (W >= IDX_W) begin : g_full
            assign mask_arr[t] = '1;
        end else begin : g_part
            assign mask_arr[t] = IDX_W'((32'd1 << W) - 32'd1);
        end
    end

    logic [IDX_W-1:0] mask;
    always_comb begin
        mask = mask_arr[tbl];
        addr = {tbl, idx_a & mask, idx_b & mask};
    end
endmodule

// File: rtl/qlut_mem.sv
module qlut_mem #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    // synchronous read: a same-edge write is not yet visible
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_q <= store[rd_addr];
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/qlut_unit.sv
module qlut_unit
    import qlut_pkg::*;
#(
    parameter int NUM_TABLES = DEF_NUM_TABLES,
    parameter int IDX_W      = DEF_IDX_W,
    parameter int OUT_W      = DEF_OUT_W,
    parameter int DST_W      = DEF_DST_W,
    parameter logic [NUM_TABLES*4-1:0] TBL_IW = {4'd2, 4'd3, 4'd4, 4'd4},
    localparam int TID_W  = $clog2(NUM_TABLES),
    localparam int ADDR_W = TID_W + 2 * IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [OUT_W-1:0]  ld_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [TID_W-1:0]  req_tbl,
    input  logic [IDX_W-1:0]  req_a,
    input  logic [IDX_W-1:0]  req_b,
    input  logic [DST_W-1:0]  req_dst,
    output logic              res_valid,
    output logic [OUT_W-1:0]  res_data,
    output logic [DST_W-1:0]  res_dst
);
    typedef struct packed {
        logic [TID_W-1:0]  act;
        logic              wr_v;
        logic [ADDR_W-1:0] wr_addr;
        logic [OUT_W-1:0]  wr_data;
        logic              res_v;
        logic [DST_W-1:0]  res_dst;
    } state_t;

    state_t st_d, st_q;

    qlut_op_e          op;
    logic              accept;
    logic              is_lookup;
    logic [TID_W-1:0]  sel_tbl;
    logic [ADDR_W-1:0] rd_addr;

    always_comb begin
        op        = qlut_op_e'(req_op);
        accept    = req_valid && req_ready;
        is_lookup = (op == OP_LOOKUP_ACT) || (op == OP_LOOKUP_TBL);
        sel_tbl   = (op == OP_LOOKUP_TBL) ? req_tbl : st_q.act;
    end

    qlut_addr #(
        .NUM_TABLES (NUM_TABLES),
        .IDX_W      (IDX_W),
        .TBL_IW     (TBL_IW)
    ) u_addr (
        .tbl   (sel_tbl),
        .idx_a (req_a),
        .idx_b (req_b),
        .addr  (rd_addr)
    );

    qlut_mem #(
        .ADDR_W (ADDR_W),
        .DATA_W (OUT_W)
    ) u_mem (
        .clk     (clk),
        .wr_en   (st_q.wr_v),
        .wr_addr (st_q.wr_addr),
        .wr_data (st_q.wr_data),
        .rd_en   (accept && is_lookup),
        .rd_addr (rd_addr),
        .rd_data (res_data)
    );

    always_comb begin
        st_d         = st_q;
        // load port is staged one cycle; the memory write happens from the stage
        st_d.wr_v    = ld_en;
        st_d.wr_addr = ld_addr;
        st_d.wr_data = ld_data;
        st_d.res_v   = accept && is_lookup;
        if (accept && is_lookup) begin
            st_d.res_dst = req_dst;
        end
        if (accept && (op == OP_SET_ACT)) begin
            st_d.act = req_tbl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = !st_q.wr_v;
    assign res_valid = st_q.res_v;
    assign res_dst   = st_q.res_dst;
endmodule

// File: rtl/qlut_unit_chk.sv
module qlut_unit_chk #(
    parameter int TID_W = 2,
    parameter int DST_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_en,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       req_op,
    input logic [TID_W-1:0] req_tbl,
    input logic [DST_W-1:0] req_dst,
    input logic             res_valid,
    input logic [DST_W-1:0] res_dst
);
    logic acc_lookup;
    assign acc_lookup = req_valid && req_ready && !req_op[1];

    // R10: an accepted lookup yields a result on the next cycle
    a_r10_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc_lookup |=> res_valid);

    // R10: no result without an accepted lookup
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_lookup |=> !res_valid);

    // R2: destination tag travels with the result
    a_r2_dst_echo: assert property (@(posedge clk) disable iff (!rst_n)
        acc_lookup |=> (res_dst == $past(req_dst)));

    // R4: set-table gives no result
    a_r4_set_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 2'd2) |=> !res_valid);

    // R9: reserved command gives no result
    a_r9_rsvd_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 2'd3) |=> !res_valid);

    // R7: ready drops for the cycle after a load, otherwise stays high
    a_r7_ready_low_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> !req_ready);
    a_r7_ready_high_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> req_ready);
endmodule

bind qlut_unit qlut_unit_chk #(
    .TID_W (TID_W),
    .DST_W (DST_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_en     (ld_en),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_tbl   (req_tbl),
    .req_dst   (req_dst),
    .res_valid (res_valid),
    .res_dst   (res_dst)
);

// File: tb/qlut_unit_tb.sv
module qlut_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ld_en;
    logic [9:0] ld_addr;
    logic [8:0] ld_data;
    logic       req_valid;
    logic       req_ready;
    logic [1:0] req_op;
    logic [1:0] req_tbl;
    logic [3:0] req_a;
    logic [3:0] req_b;
    logic [3:0] req_dst;
    logic       res_valid;
    logic [8:0] res_data;
    logic [3:0] res_dst;

    int checks   = 0;
    int failures = 0;
    logic [8:0] model [1024];

    always #(CLK_PERIOD / 2) clk = ~clk;

    qlut_unit u_dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_tbl(req_tbl),
        .req_a(req_a), .req_b(req_b), .req_dst(req_dst),
        .res_valid(res_valid), .res_data(res_data), .res_dst(res_dst)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int tw(input int t);
        case (t)
            2: return 3;
            3: return 2;
            default: return 4;
        endcase
    endfunction

    function automatic int entry(input int t, input int a, input int b);
        int m = (1 << tw(t)) - 1;
        return int'(model[t*256 + (a & m)*16 + (b & m)]);
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // drive one request; result is sampled just after the accepting edge
    task automatic lookup(input int op, input int tbl, input int a, input int b,
                          input int dst, input int exp_t, input string req);
        req_valid = 1'b1;
        req_op = 2'(op); req_tbl = 2'(tbl);
        req_a = 4'(a); req_b = 4'(b); req_dst = 4'(dst);
        step();
        chk({req, " res_valid"}, int'(res_valid), 1);
        chk({req, " res_data"}, int'(res_data), entry(exp_t, a, b));
        chk({req, " res_dst"}, int'(res_dst), dst);
    endtask

    task automatic command(input int op, input int tbl, input string req);
        req_valid = 1'b1;
        req_op = 2'(op); req_tbl = 2'(tbl);
        step();
        chk({req, " no result"}, int'(res_valid), 0);
    endtask

    task automatic idle(input string req);
        req_valid = 1'b0;
        step();
        chk({req, " idle res_valid"}, int'(res_valid), 0);
    endtask

    task automatic t_reset();
        chk("R1 res_valid after reset", int'(res_valid), 0);
        chk("R1 ready after reset", int'(req_ready), 1);
    endtask

    task automatic t_load_all();
        for (int i = 0; i < 1024; i++) begin
            model[i] = 9'((i * 37 + (i >> 4) * 11 + 5) % 512);
            ld_en = 1'b1; ld_addr = 10'(i); ld_data = model[i];
            step();
        end
        ld_en = 1'b0;
        step();
        chk("R7 ready back after loads", int'(req_ready), 1);
    endtask

    task automatic t_default_active();
        lookup(0, 3, 5, 9, 1, 0, "R1 implicit reads table 0");
        lookup(0, 2, 15, 0, 2, 0, "R1 implicit reads table 0 again");
        idle("R10");
    endtask

    task automatic t_explicit();
        // back to back, one result per cycle (R10), address {t,a,b} per R5
        lookup(1, 0, 3, 12, 3, 0, "R2 R5 explicit t0");
        lookup(1, 1, 15, 15, 4, 1, "R2 R5 explicit t1");
        lookup(1, 2, 7, 1, 5, 2, "R2 explicit t2");
        lookup(1, 3, 2, 3, 6, 3, "R2 explicit t3");
        lookup(1, 1, 0, 0, 7, 1, "R10 back to back");
        idle("R10");
    endtask

    task automatic t_set_active();
        command(2, 1, "R4 set-table");
        lookup(0, 0, 6, 10, 8, 1, "R3 implicit after set");
        lookup(1, 3, 1, 1, 9, 3, "R4 explicit t3");
        lookup(0, 0, 9, 4, 10, 1, "R4 active unchanged by explicit");
        lookup(0, 2, 14, 13, 11, 1, "R3 setting persists");
        idle("R3");
    endtask

    task automatic t_mask();
        lookup(1, 2, 11, 14, 12, 2, "R6 t2 high bits ignored");
        lookup(1, 3, 15, 5, 13, 3, "R6 t3 high bits ignored");
        command(2, 2, "R6 set t2");
        lookup(0, 0, 8, 15, 14, 2, "R6 implicit t2 masked");
        command(2, 1, "R6 restore t1");
        idle("R6");
    endtask

    task automatic t_reserved();
        command(3, 2, "R9 reserved");
        lookup(0, 0, 4, 4, 15, 1, "R9 active unchanged by reserved");
        idle("R9");
    endtask

    task automatic t_collision();
        int adr = 0 * 256 + 5 * 16 + 6;
        int old_v = int'(model[adr]);
        int new_v = (old_v + 100) % 512;
        ld_en = 1'b1; ld_addr = 10'(adr); ld_data = 9'(new_v);
        req_valid = 1'b1; req_op = 2'd1; req_tbl = 2'd0;
        req_a = 4'd5; req_b = 4'd6; req_dst = 4'd2;
        chk("R7 ready before collision", int'(req_ready), 1);
        step();
        chk("R8 same-cycle read valid", int'(res_valid), 1);
        chk("R8 same-cycle read old", int'(res_data), old_v);
        chk("R7 ready low after load", int'(req_ready), 0);
        ld_en = 1'b0;
        step();
        chk("R7 stalled request no result", int'(res_valid), 0);
        chk("R7 ready high again", int'(req_ready), 1);
        model[adr] = 9'(new_v);
        step();
        chk("R8 retry valid", int'(res_valid), 1);
        chk("R8 retry reads new", int'(res_data), new_v);
        idle("R8");
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ld_en = 1'b0; ld_addr = '0; ld_data = '0;
        req_valid = 1'b0; req_op = '0; req_tbl = '0; req_a = '0; req_b = '0; req_dst = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        step();
        t_reset();
        t_load_all();
        t_default_active();
        t_explicit();
        t_set_active();
        t_mask();
        t_reserved();
        t_collision();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule